// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block holds one reservation for each of several thread contexts. A reservation is a valid bit plus the address granule it covers. A locked load from a context records the granule of its physical address and arms that context's reservation. A later store-conditional from the same context succeeds only when the reservation is still armed and the store falls in the same 16-byte granule. When the store-conditional fails, the store must not reach memory.

Every store that actually writes memory removes the reservations that other contexts hold on that granule. Such a store is an ordinary store, a successful store-conditional or an uncacheable store-conditional. The monitor keeps a count of consecutive failed store-conditionals for each context. Each time a context's count reaches a whole multiple of a configurable period, the monitor emits a one-cycle warning that names the context, so that a possible livelock can be reported. An uncacheable store-conditional skips the reservation check. It is always performed, it reports no result and it resets the issuing context's failure count.

All results come out registered, one clock after the request is presented. The load port and the store port can both be active in the same cycle.

Top module: `rsv_monitor`

## Requirements
- R1: While reset is active, and after it, every output is 0 and every reservation and failure count is cleared. A store-conditional issued right after reset fails.
- R2: A locked load (ldValid=1, ldLocked=1) arms the reservation of context ldCtx. A later cacheable store-conditional from that context to the same granule gives scValid=1, scPass=1 and stPerform=1 one cycle after it is presented. A success also consumes the issuer's reservation.
- R3: Granules are compared on address bits [ADDR_W-1:GRAN_BITS]. Addresses that differ only below GRAN_BITS (4 by default, so 16 bytes) match. A difference in bit GRAN_BITS makes the store-conditional fail.
- R4: A failed cacheable store-conditional gives scValid=1, scPass=0 and stPerform=0, and it disarms the issuer's reservation.
- R5: A successful store-conditional disarms the reservation of every context whose granule equals the store granule. Reservations on other granules stay armed.
- R6: An ordinary store (stValid=1, stCond=0) always gives stPerform=1 and scValid=0, and it disarms every matching reservation.
- R7: A store-conditional with stUncache=1 gives scValid=0 and stPerform=1. It resets the issuer's failure count and disarms every matching reservation.
- R8: Each failed cacheable store-conditional adds one to the issuer's consecutive-failure count, and a success clears that count. Each time the count reaches a multiple of WARN_PERIOD, warnPulse is 1 for one cycle, together with the failing result, and warnCtx gives the context.
- R9: When a locked load and a store to the same granule arrive in the same cycle, the load's new reservation survives.
- R10: A store-conditional uses its context's reservation as it stood before the cycle. A locked load from the same context in the same cycle does not make that store-conditional succeed, but the reservation it sets is armed afterwards.
- R11: A load with ldLocked=0 leaves all reservations unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Load request present |
| ldLocked | input | 1 | Load is a locked (reserving) load |
| ldCtx | input | CTX_W | Issuing context of the load |
| ldAddr | input | ADDR_W | Physical address of the load |
| stValid | input | 1 | Store request present |
| stCond | input | 1 | Store is a store-conditional |
| stUncache | input | 1 | Store targets uncacheable space |
| stCtx | input | CTX_W | Issuing context of the store |
| stAddr | input | ADDR_W | Physical address of the store |
| scValid | output | 1 | A cacheable store-conditional result is presented |
| scPass | output | 1 | That store-conditional succeeded |
| stPerform | output | 1 | The store of the previous cycle may write memory |
| warnPulse | output | 1 | The failure count reached a multiple of WARN_PERIOD |
| warnCtx | output | CTX_W | Context the warning refers to |

## Verification
The bench builds the monitor with four contexts, 16-bit addresses, 16-byte granules and WARN_PERIOD set to 4. The short warning period brings a livelock warning within a handful of failing store-conditionals. With it, a run can show two things: the warning recurs per context, and an uncacheable store-conditional resets the count, which delays the next warning. Four contexts are enough to show that a sweep disarms several reservations on one granule at once while a reservation on another granule survives.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  // Strobes from the control decode to the reservation datapath.
  typedef struct packed {
    logic lock;      // arm reservation of the load context
    logic sweep;     // disarm all reservations on the store granule
    logic failSelf;  // disarm the store context's reservation
    logic cntInc;    // count one more failure for the store context
    logic cntClr;    // clear the store context's failure count
  } rsvStrobe_t;
endpackage

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ldValid,
  input  logic       ldLocked,
  input  logic       stValid,
  input  logic       stCond,
  input  logic       stUncache,
  input  logic       resHit,
  output rsvStrobe_t strb,
  output logic       scValid,
  output logic       scPass,
  output logic       stPerform
);
  logic cachedSc;
  logic uncachedSc;
  logic plainStore;
  logic scWins;
  logic writes;

  always_comb begin
    cachedSc   = stValid && stCond && !stUncache;
    uncachedSc = stValid && stCond && stUncache;
    plainStore = stValid && !stCond;
    scWins     = cachedSc && resHit;
    writes     = plainStore || uncachedSc || scWins;

    strb          = '0;
    strb.lock     = ldValid && ldLocked;
    strb.sweep    = writes;
    strb.failSelf = cachedSc && !resHit;
    strb.cntInc   = cachedSc && !resHit;
    strb.cntClr   = uncachedSc || scWins;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scValid   <= 1'b0;
      scPass    <= 1'b0;
      stPerform <= 1'b0;
    end else begin
      scValid   <= cachedSc;
      scPass    <= scWins;
      stPerform <= writes;
    end
  end
endmodule

// File: rtl/rsv_datapath.sv
module rsv_datapath
  import rsv_pkg::*;
#(
  parameter int NUM_CTX     = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000,
  localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int TAG_W      = ADDR_W - GRAN_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  rsvStrobe_t       strb,
  input  logic [CTX_W-1:0] ldCtx,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [CTX_W-1:0] stCtx,
  input  logic [ADDR_W-1:0] stAddr,
  output logic             resHit,
  output logic             warnPulse,
  output logic [CTX_W-1:0] warnCtx
);
  localparam int CNT_W = $clog2(WARN_PERIOD + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WARN_PERIOD - 1);

  logic [TAG_W-1:0] ldTag;
  logic [TAG_W-1:0] stTag;
  logic [NUM_CTX-1:0] armed;
  logic [TAG_W-1:0]   tagMem [NUM_CTX];
  logic [NUM_CTX-1:0] atLast;
  logic [NUM_CTX-1:0] sameGran;

  assign ldTag = ldAddr[ADDR_W-1:GRAN_BITS];
  assign stTag = stAddr[ADDR_W-1:GRAN_BITS];

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic [CNT_W-1:0] failCnt;
    logic ldHere;
    logic stHere;

    assign ldHere      = strb.lock && (ldCtx == CTX_W'(c));
    assign stHere      = (stCtx == CTX_W'(c));
    assign sameGran[c] = (tagMem[c] == stTag);
    assign atLast[c]   = (failCnt == CNT_LAST);

    // Reservation: a new lock beats any clearing in the same cycle.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        armed[c]  <= 1'b0;
        tagMem[c] <= '0;
      end else if (ldHere) begin
        armed[c]  <= 1'b1;
        tagMem[c] <= ldTag;
      end else if (strb.sweep && sameGran[c]) begin
        armed[c] <= 1'b0;
      end else if (strb.failSelf && stHere) begin
        armed[c] <= 1'b0;
      end
    end

    // Consecutive failure count, wrapping at the warning period.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        failCnt <= '0;
      end else if (stHere && strb.cntClr) begin
        failCnt <= '0;
      end else if (stHere && strb.cntInc) begin
        failCnt <= atLast[c] ? '0 : failCnt + 1'b1;
      end
    end
  end

  assign resHit = armed[stCtx] && sameGran[stCtx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warnPulse <= 1'b0;
      warnCtx   <= '0;
    end else begin
      warnPulse <= strb.cntInc && atLast[stCtx];
      warnCtx   <= stCtx;
    end
  end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int NUM_CTX     = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000,
  localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldValid,
  input  logic              ldLocked,
  input  logic [CTX_W-1:0]  ldCtx,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              stValid,
  input  logic              stCond,
  input  logic              stUncache,
  input  logic [CTX_W-1:0]  stCtx,
  input  logic [ADDR_W-1:0] stAddr,
  output logic              scValid,
  output logic              scPass,
  output logic              stPerform,
  output logic              warnPulse,
  output logic [CTX_W-1:0]  warnCtx
);
  rsvStrobe_t strb;
  logic       resHit;

  rsv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .ldValid(ldValid), .ldLocked(ldLocked),
    .stValid(stValid), .stCond(stCond), .stUncache(stUncache),
    .resHit(resHit), .strb(strb),
    .scValid(scValid), .scPass(scPass), .stPerform(stPerform)
  );

  rsv_datapath #(
    .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W),
    .GRAN_BITS(GRAN_BITS), .WARN_PERIOD(WARN_PERIOD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ldCtx(ldCtx), .ldAddr(ldAddr),
    .stCtx(stCtx), .stAddr(stAddr),
    .resHit(resHit), .warnPulse(warnPulse), .warnCtx(warnCtx)
  );
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk (
  input logic clk,
  input logic rstN,
  input logic stValid,
  input logic stCond,
  input logic stUncache,
  input logic scValid,
  input logic scPass,
  input logic stPerform,
  input logic warnPulse
);
  logic armedChk;
  always_ff @(posedge clk) armedChk <= rstN;

  p_pass_has_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    scPass |-> scValid);

  p_pass_performs_r2: assert property (@(posedge clk) disable iff (!rstN)
    (scValid && scPass) |-> stPerform);

  p_fail_blocks_store_r4: assert property (@(posedge clk) disable iff (!rstN)
    (scValid && !scPass) |-> !stPerform);

  p_plain_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    (armedChk && $past(stValid && !stCond)) |-> (stPerform && !scValid));

  p_uncached_sc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (armedChk && $past(stValid && stCond && stUncache)) |-> (stPerform && !scValid));

  p_warn_on_fail_r8: assert property (@(posedge clk) disable iff (!rstN)
    warnPulse |-> (scValid && !scPass));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (armedChk && $past(!stValid)) |-> (!scValid && !stPerform && !warnPulse));
endmodule

bind rsv_monitor rsv_monitor_chk u_chk (
  .clk(clk), .rstN(rstN),
  .stValid(stValid), .stCond(stCond), .stUncache(stUncache),
  .scValid(scValid), .scPass(scPass), .stPerform(stPerform),
  .warnPulse(warnPulse)
);

// File: tb/rsv_monitor_tb.sv
module rsv_monitor_tb;
  localparam int NCTX = 4;
  localparam int AW   = 16;
  localparam int CW   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldValid = 1'b0, ldLocked = 1'b0;
  logic [CW-1:0] ldCtx = '0;
  logic [AW-1:0] ldAddr = '0;
  logic stValid = 1'b0, stCond = 1'b0, stUncache = 1'b0;
  logic [CW-1:0] stCtx = '0;
  logic [AW-1:0] stAddr = '0;
  logic scValid, scPass, stPerform, warnPulse;
  logic [CW-1:0] warnCtx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rsv_monitor #(.NUM_CTX(NCTX), .ADDR_W(AW), .GRAN_BITS(4), .WARN_PERIOD(4)) u_dut (
    .clk(clk), .rstN(rstN),
    .ldValid(ldValid), .ldLocked(ldLocked), .ldCtx(ldCtx), .ldAddr(ldAddr),
    .stValid(stValid), .stCond(stCond), .stUncache(stUncache),
    .stCtx(stCtx), .stAddr(stAddr),
    .scValid(scValid), .scPass(scPass), .stPerform(stPerform),
    .warnPulse(warnPulse), .warnCtx(warnCtx)
  );

  // load kinds: none, plain, locked; store kinds: none, ordinary, cond, uncached cond
  localparam logic [1:0] LN = 2'd0, LP = 2'd1, LL = 2'd2;
  localparam logic [1:0] SN = 2'd0, SO = 2'd1, SS = 2'd2, SU = 2'd3;
  localparam logic T = 1'b1, F = 1'b0;

  typedef struct packed {
    logic [1:0]  ldK;
    logic [1:0]  ldC;
    logic [15:0] ldA;
    logic [1:0]  stK;
    logic [1:0]  sC;
    logic [15:0] sA;
    logic        eV;
    logic        eP;
    logic        eF;
    logic        eW;
    logic [1:0]  eWc;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 33;
  localparam vec_t TBL [NVEC] = '{
    '{LN,2'd0,16'h0000, SS,2'd0,16'h1000, T,F,F,F,2'd0,8'd1},  // R1 no reservation
    '{LL,2'd0,16'h1004, SN,2'd0,16'h0000, F,F,F,F,2'd0,8'd2},  // R2 arm ctx0
    '{LN,2'd0,16'h0000, SS,2'd0,16'h100C, T,T,T,F,2'd0,8'd3},  // R3 low bits ignored
    '{LN,2'd0,16'h0000, SS,2'd0,16'h1000, T,F,F,F,2'd0,8'd2},  // R2 consumed
    '{LL,2'd1,16'h2000, SN,2'd0,16'h0000, F,F,F,F,2'd0,8'd2},
    '{LN,2'd0,16'h0000, SS,2'd1,16'h2010, T,F,F,F,2'd0,8'd3},  // R3 bit 4 differs
    '{LN,2'd0,16'h0000, SS,2'd1,16'h2000, T,F,F,F,2'd0,8'd4},  // R4 disarmed by fail
    '{LL,2'd0,16'h3000, SN,2'd0,16'h0000, F,F,F,F,2'd0,8'd5},
    '{LL,2'd1,16'h3008, SN,2'd0,16'h0000, F,F,F,F,2'd0,8'd5},
    '{LL,2'd2,16'h4000, SN,2'd0,16'h0000, F,F,F,F,2'd0,8'd5},
    '{LN,2'd0,16'h0000, SS,2'd0,16'h3004, T,T,T,F,2'd0,8'd5},  // R5 sweep
    '{LN,2'd0,16'h0000, SS,2'd1,16'h3000, T,F,F,F,2'd0,8'd5},  // R5 ctx1 swept
    '{LN,2'd0,16'h0000, SS,2'd2,16'h4000, T,T,T,F,2'd0,8'd5},  // R5 other granule kept
    '{LL,2'd3,16'h5000, SN,2'd0,16'h0000, F,F,F,F,2'd0,8'd6},
    '{LN,2'd0,16'h0000, SO,2'd0,16'h5008, F,F,T,F,2'd0,8'd6},  // R6 ordinary store
    '{LN,2'd0,16'h0000, SS,2'd3,16'h5000, T,F,F,F,2'd0,8'd6},  // R6 swept
    '{LN,2'd0,16'h0000, SS,2'd1,16'h9000, T,F,F,T,2'd1,8'd8},  // R8 fourth fail of ctx1
    '{LL,2'd2,16'h6000, SO,2'd0,16'h6000, F,F,T,F,2'd0,8'd9},  // R9 same cycle
    '{LN,2'd0,16'h0000, SS,2'd2,16'h6004, T,T,T,F,2'd0,8'd9},  // R9 load won
    '{LL,2'd0,16'h7000, SS,2'd0,16'h7000, T,F,F,F,2'd0,8'd10}, // R10 old flag used
    '{LN,2'd0,16'h0000, SS,2'd0,16'h7000, T,T,T,F,2'd0,8'd10}, // R10 new flag armed
    '{LL,2'd1,16'h8000, SN,2'd0,16'h0000, F,F,F,F,2'd0,8'd11},
    '{LP,2'd1,16'h9000, SN,2'd0,16'h0000, F,F,F,F,2'd0,8'd11}, // R11 plain load
    '{LN,2'd0,16'h0000, SS,2'd1,16'h8000, T,T,T,F,2'd0,8'd11}, // R11 reservation intact
    '{LN,2'd0,16'h0000, SS,2'd3,16'hA000, T,F,F,F,2'd0,8'd8},
    '{LN,2'd0,16'h0000, SS,2'd3,16'hA000, T,F,F,F,2'd0,8'd8},
    '{LL,2'd2,16'hB000, SN,2'd0,16'h0000, F,F,F,F,2'd0,8'd7},
    '{LN,2'd0,16'h0000, SU,2'd3,16'hB000, F,F,T,F,2'd0,8'd7},  // R7 uncached SC
    '{LN,2'd0,16'h0000, SS,2'd2,16'hB000, T,F,F,F,2'd0,8'd7},  // R7 swept ctx2
    '{LN,2'd0,16'h0000, SS,2'd3,16'hA000, T,F,F,F,2'd0,8'd7},  // R7 count restarted
    '{LN,2'd0,16'h0000, SS,2'd3,16'hA000, T,F,F,F,2'd0,8'd8},
    '{LN,2'd0,16'h0000, SS,2'd3,16'hA000, T,F,F,F,2'd0,8'd8},
    '{LN,2'd0,16'h0000, SS,2'd3,16'hA000, T,F,F,T,2'd3,8'd8}   // R8 warn ctx3
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ldValid = 1'b0; ldLocked = 1'b0; ldCtx = '0; ldAddr = '0;
    stValid = 1'b0; stCond = 1'b0; stUncache = 1'b0; stCtx = '0; stAddr = '0;
  endtask

  task automatic apply(input vec_t v);
    ldValid  = (v.ldK != LN);
    ldLocked = (v.ldK == LL);
    ldCtx    = v.ldC;
    ldAddr   = v.ldA;
    stValid  = (v.stK != SN);
    stCond   = (v.stK == SS) || (v.stK == SU);
    stUncache = (v.stK == SU);
    stCtx    = v.sC;
    stAddr   = v.sA;
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1", "scValid in reset", int'(scValid), 0);
    chk("R1", "stPerform in reset", int'(stPerform), 0);
    chk("R1", "warnPulse in reset", int'(warnPulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "scValid after reset", int'(scValid), 0);

    for (int i = 0; i < NVEC; i++) begin
      string rq;
      rq = $sformatf("R%0d vec%0d", TBL[i].req, i);
      apply(TBL[i]);
      @(negedge clk);
      chk(rq, "scValid", int'(scValid), int'(TBL[i].eV));
      chk(rq, "scPass", int'(scPass), int'(TBL[i].eP));
      chk(rq, "stPerform", int'(stPerform), int'(TBL[i].eF));
      chk(rq, "warnPulse", int'(warnPulse), int'(TBL[i].eW));
      if (TBL[i].eW) chk(rq, "warnCtx", int'(warnCtx), int'(TBL[i].eWc));
    end
    idle();
    @(negedge clk);
    chk("R1", "idle scValid", int'(scValid), 0);

    // R1: reset in the middle clears an armed reservation
    ldValid = 1'b1; ldLocked = 1'b1; ldCtx = 2'd2; ldAddr = 16'hC000;
    @(negedge clk);
    idle();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    stValid = 1'b1; stCond = 1'b1; stCtx = 2'd2; stAddr = 16'hC000;
    @(negedge clk);
    chk("R1", "SC after mid reset valid", int'(scValid), 1);
    chk("R1", "SC after mid reset pass", int'(scPass), 0);
    chk("R1", "SC after mid reset perform", int'(stPerform), 0);
    idle();
    @(negedge clk);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule